// File: doc/BRIEF.md
# PCIe Interrupt Aggregation Wrapper

This block sits between a PCIe controller core and the CPU's interrupt controller. Per-vector MSI event pulses from the core are collected into a vector status register. Four legacy INTx level inputs and one aggregate MSI indication are latched into a wrapper status register. Any set bit in the wrapper status register drives a single interrupt line towards the CPU.

Software reaches both registers through a simple register bus. A read strobe and an address select a register, and a write strobe clears every bit of that register that is written as one. Combinational read data shows the current content of the addressed register.

The aggregate MSI bit follows an arm/disarm rule. It latches on the first vector event that arrives while it is armed, and that latch disarms it. It is armed again only by a read of the vector status register, at a moment when every vector bit is clear. The handler therefore has to drain the vectors until it sees a zero read. Vectors that are still pending when software clears the wrapper bit raise no new interrupt.

Top module: `pcie_irq_aggregator`

## Requirements
- R1: After reset both status registers read zero, `irq_o` is low, and the MSI latch is armed, so the first vector event raises the aggregate bit.
- R2: A pulse on `msi_set_i[n]` sets vector bit n in the next cycle. A write to the vector register (address 1) clears each bit written as one and leaves the others alone. If an event and a clear hit the same bit in the same cycle, the bit stays set.
- R3: Wrapper bits 0 to 3 latch `intx_i[3:0]` while the input is high. A clear of such a bit takes effect only when its input is low in that cycle; otherwise the bit stays set.
- R4: While armed, any vector event sets wrapper bit 4 in the next cycle and disarms the latch.
- R5: While disarmed and without a zero read, vector events still set vector bits but leave wrapper bit 4 unchanged.
- R6: A read strobe to the vector register in a cycle where all vector bits are zero re-arms the latch. A read that returns a nonzero value does not re-arm it.
- R7: A vector event that arrives in the same cycle as a zero read sets wrapper bit 4.
- R8: Writing ones to the wrapper register (address 0) clears those bits. If the aggregate bit is set and cleared in the same cycle, the set wins.
- R9: `irq_o` is high exactly when any wrapper status bit is set.
- R10: Read data is zero-extended. Address 0 returns the wrapper bits in [4:0], address 1 returns the vector bits, and any other address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_set_i | input | NVEC | Per-vector MSI event pulses |
| intx_i | input | 4 | Legacy INTA..INTD levels |
| bus_addr_i | input | ADDR_W | Register address |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe (write-one-to-clear) |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data of the addressed register |
| irq_o | output | 1 | Interrupt line to the CPU |

## Verification
The bench builds the block with its defaults: 32 vectors, 32-bit data and a 2-bit address. That makes the top vector bit (31) reachable, along with the two unused addresses, which must read zero. With these values, events at the highest vector index and the same-cycle collisions of event with clear, and of zero read with event, can be driven directly. A behavioural model tracks the arm state and is compared against read data and the interrupt line on every clock.

// File: rtl/pcie_irq_aggregator.sv
module pcie_irq_aggregator #(
  parameter int NVEC      = 32,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 2,
  parameter int WRAP_ADDR = 0,
  parameter int VEC_ADDR  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NVEC-1:0]   msi_set_i,
  input  logic [3:0]        intx_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  localparam int NLEG   = 4;
  localparam int WRAP_W = NLEG + 1;

  logic [NVEC-1:0]   vec_q;
  logic [WRAP_W-1:0] wrap_q;
  logic              armed_q;

  wire sel_wrap = (bus_addr_i == ADDR_W'(WRAP_ADDR));
  wire sel_vec  = (bus_addr_i == ADDR_W'(VEC_ADDR));

  wire [NVEC-1:0]   vec_clr  = (bus_wr_i && sel_vec)  ? bus_wdata_i[NVEC-1:0]   : '0;
  wire [WRAP_W-1:0] wrap_clr = (bus_wr_i && sel_wrap) ? bus_wdata_i[WRAP_W-1:0] : '0;

  wire zero_rd  = bus_rd_i && sel_vec && (vec_q == '0);
  wire msi_fire = (|msi_set_i) && (armed_q || zero_rd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q   <= '0;
      wrap_q  <= '0;
      armed_q <= 1'b1;
    end else begin
      vec_q   <= (vec_q & ~vec_clr) | msi_set_i;
      wrap_q  <= (wrap_q & ~wrap_clr) | {msi_fire, intx_i};
      if (msi_fire)     armed_q <= 1'b0;
      else if (zero_rd) armed_q <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (sel_vec)       bus_rdata_o[NVEC-1:0]   = vec_q;
    else if (sel_wrap) bus_rdata_o[WRAP_W-1:0] = wrap_q;
  end

  assign irq_o = |wrap_q;
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
  parameter int NVEC     = 32,
  parameter int ADDR_W   = 2,
  parameter int VEC_ADDR = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NVEC-1:0]   msi_set_i,
  input logic [3:0]        intx_i,
  input logic              bus_rd_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [NVEC-1:0]   vec_q,
  input logic [4:0]        wrap_q,
  input logic              armed_q
);
  logic zr;
  assign zr = bus_rd_i && (bus_addr_i == ADDR_W'(VEC_ADDR)) && (vec_q == '0);

  assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_set_i != '0) |=> ((vec_q & $past(msi_set_i)) == $past(msi_set_i)));

  assert_intx_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (intx_i != 4'd0) |=> ((wrap_q[3:0] & $past(intx_i)) == $past(intx_i)));

  assert_armed_fire_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && msi_set_i != '0) |=> (wrap_q[4] && !armed_q));

  assert_disarmed_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !zr && !wrap_q[4]) |=> !wrap_q[4]);

  assert_zero_read_arms_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (zr && msi_set_i == '0) |=> armed_q);

  assert_nonzero_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !zr && msi_set_i == '0) |=> !armed_q);

  assert_zero_read_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (zr && msi_set_i != '0) |=> wrap_q[4]);
endmodule

bind pcie_irq_aggregator irq_agg_chk #(
  .NVEC(NVEC), .ADDR_W(ADDR_W), .VEC_ADDR(VEC_ADDR)
) chk_i (
  .clk(clk), .rst_n(rst_n), .msi_set_i(msi_set_i), .intx_i(intx_i),
  .bus_rd_i(bus_rd_i), .bus_addr_i(bus_addr_i),
  .vec_q(vec_q), .wrap_q(wrap_q), .armed_q(armed_q)
);

// File: tb/pcie_irq_aggregator_tb_top.sv
`timescale 1ns/1ps
module pcie_irq_aggregator_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] msi = '0;
  logic [3:0]  intx = '0;
  logic [1:0]  addr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pcie_irq_aggregator dut_i (
    .clk(clk), .rst_n(rst_n), .msi_set_i(msi), .intx_i(intx),
    .bus_addr_i(addr), .bus_rd_i(rd), .bus_wr_i(wr), .bus_wdata_i(wd),
    .bus_rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference model
  logic [31:0] m_vec;
  logic [4:0]  m_wrap;
  bit          m_arm;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_vec = '0; m_wrap = '0; m_arm = 1;
    end else begin
      bit zr, fire;
      zr   = rd && addr == 2'd1 && m_vec == 0;
      fire = (msi != 0) && (m_arm || zr);
      for (int i = 0; i < 32; i++)
        if (msi[i]) m_vec[i] = 1'b1;
        else if (wr && addr == 2'd1 && wd[i]) m_vec[i] = 1'b0;
      for (int i = 0; i < 4; i++)
        if (intx[i]) m_wrap[i] = 1'b1;
        else if (wr && addr == 2'd0 && wd[i]) m_wrap[i] = 1'b0;
      if (fire) m_wrap[4] = 1'b1;
      else if (wr && addr == 2'd0 && wd[4]) m_wrap[4] = 1'b0;
      if (fire) m_arm = 0;
      else if (zr) m_arm = 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      logic [31:0] er;
      er = (addr == 2'd0) ? {27'd0, m_wrap} : (addr == 2'd1) ? m_vec : 32'd0;
      check("R10 model rdata", rdata, er);
      check("R9 model irq", {31'd0, irq}, {31'd0, |m_wrap});
    end
  end

  task automatic cyc(input logic [1:0] a, input logic r, input logic w,
                     input logic [31:0] d, input logic [31:0] m);
    @(negedge clk);
    addr = a; rd = r; wr = w; wd = d; msi = m;
  endtask

  task automatic idle();
    cyc(2'd0, 0, 0, 0, 0);
  endtask

  // peek without read strobe side effects: address 0 only, or vector when nonzero
  task automatic peek(input logic [1:0] a, input string tag, input logic [31:0] exp);
    cyc(a, (a == 2'd1), 0, 0, 0);
    #1 check(tag, rdata, exp);
  endtask

  task automatic irq_is(input string tag, input logic exp);
    @(negedge clk); #1 check(tag, {31'd0, irq}, {31'd0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check("R1 wrap reset", rdata, 0);
    check("R1 irq reset", {31'd0, irq}, 0);
    cyc(2'd3, 0, 0, 0, 0); #1 check("R10 unused addr", rdata, 0);

    cyc(0, 0, 0, 0, 32'h8);               // armed -> fires
    idle();
    #1 check("R4 wrap bit4", rdata, 32'h10);
    check("R9 irq high", {31'd0, irq}, 1);
    peek(1, "R2 vec bit3", 32'h8);
    cyc(0, 0, 0, 0, 32'h20);              // disarmed
    idle(); #1 check("R5 wrap unchanged", rdata, 32'h10);
    cyc(0, 0, 1, 32'h10, 0);              // clear wrap
    idle(); #1 check("R8 wrap cleared", rdata, 0);
    check("R9 irq low", {31'd0, irq}, 0);
    cyc(0, 0, 0, 0, 32'h80);
    idle(); #1 check("R5 pending no irq", rdata, 0);
    peek(1, "R2 vec accum", 32'hA8);      // nonzero read
    cyc(1, 0, 1, 32'hA8, 0);              // clear vectors
    cyc(0, 0, 0, 0, 32'h2);
    idle(); #1 check("R6 nonzero read no arm", rdata, 0);
    peek(1, "R2 partial", 32'h2);
    cyc(1, 0, 1, 32'h2, 0);
    cyc(1, 1, 0, 0, 0);                   // zero read
    #1 check("R6 zero read value", rdata, 0);
    cyc(0, 0, 0, 0, 32'h200);
    idle(); #1 check("R6 rearmed fires", rdata, 32'h10);
    cyc(1, 0, 1, 32'h200, 32'h200);       // clear collides with event
    peek(1, "R2 event wins clear", 32'h200);
    cyc(1, 0, 1, 32'h200, 0);
    cyc(1, 1, 0, 0, 0);                   // zero read arms
    cyc(0, 0, 1, 32'h10, 32'h1);          // fire and clear together
    idle(); #1 check("R8 set wins clear", rdata, 32'h10);
    cyc(0, 0, 1, 32'h10, 0);
    cyc(1, 0, 1, 32'h1, 0);
    cyc(1, 1, 0, 0, 32'h8000_0000);       // zero read with event
    idle(); #1 check("R7 same-cycle fire", rdata, 32'h10);
    peek(1, "R2 top vector", 32'h8000_0000);
    cyc(0, 0, 1, 32'h1F, 0);
    idle(); #1 check("R8 full clear", rdata, 0);

    intx = 4'b0101;
    idle(); idle(); #1 check("R3 intx latch", rdata, 32'h5);
    check("R9 irq intx", {31'd0, irq}, 1);
    cyc(0, 0, 1, 32'h5, 0);
    idle(); #1 check("R3 relatch while high", rdata, 32'h5);
    intx = 4'b0000;
    cyc(0, 0, 1, 32'h1, 0);
    idle(); #1 check("R3 partial clear", rdata, 32'h4);
    cyc(0, 0, 1, 32'h4, 0);
    irq_is("R9 irq dropped", 0);
    cyc(2'd2, 1, 0, 0, 0); #1 check("R10 addr2 zero", rdata, 0);
    repeat (3) idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule